// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block is a purely combinational binary adder. It adds two unsigned operands and a single carry input, and it returns the sum together with the carry leaving the most significant bit. A 32-bit add therefore yields a 33-bit result.

The operand width is split into equal slices. Inside a slice every carry is written as a flat two-level sum of products of per-bit generate and propagate terms, so no carry inside a slice waits on a neighbouring carry. Between slices the carry is passed along a short chain: each slice's carry-out becomes the carry-in of the slice above it. The default is 32 bits in slices of 8. Setting both the width and the slice width to 4 gives one slice, with full lookahead across the whole adder.

Top module: `cla_grouped_adder`

## Requirements
- R1: The concatenation {c_out, sum_o} equals a_op + b_op + c_in taken as an unsigned value WIDTH+1 bits wide.
- R2: For every bit, generate is a AND b and propagate is a XOR b, so the two are never both 1 at the same bit.
- R3: Each sum bit is the propagate term of that bit XOR the carry into that bit. It is 1 exactly when an odd number of its three inputs are 1.
- R4: Each slice's carry-out equals the carry of adding that slice's operand bits plus its carry-in. The carry is built from a flat expansion with one product term per lower generating bit, plus one term that propagates the slice carry-in.
- R5: Each slice's carry-out equals the majority of its top operand bits and the carry into its top bit.
- R6: Slice 0 takes c_in. Slice k takes the carry-out of slice k-1. The carry-out of the last slice drives c_out, so a carry entering at bit 0 can cross every slice boundary.
- R7: With WIDTH=4 and GROUP_W=4, the adder is a single full-lookahead slice and gives the correct 5-bit result for all 512 input combinations.
- R8: For every applied vector, the result equals that of a ripple chain of full adders of the same width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_op | input | WIDTH | First operand |
| b_op | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach from the ports is a carry that is generated at bit 0 and must pass through every slice boundary in turn. Random operands almost never propagate across a whole 8-bit slice, let alone several. The bench builds these vectors on purpose. Low masks of all ones, 8·k bits long, are added to 1, which stops the carry exactly at each boundary. All ones plus a carry-in of 1 sends the carry through every slice and out of c_out. Random vectors with both carry-in values and an exhaustive sweep of the 4-bit configuration cover the rest.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_DEF_WIDTH = 32;
  localparam int unsigned CLA_DEF_GROUP = 8;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] gen_o,
  output logic [N-1:0] prop_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end

  always_comb begin
    AST_GP_EXCLUSIVE: assert ((gen_o & prop_o) == '0); // R2
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         c_i,
  output logic [N:0]   carry_o
);
  always_comb begin
    logic acc;
    logic prod;
    carry_o[0] = c_i;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = gen_i[j];
        for (int k = j + 1; k <= i; k++) begin
          prod = prod & prop_i[k];
        end
        acc = acc | prod;
      end
      prod = c_i;
      for (int k = 0; k <= i; k++) begin
        prod = prod & prop_i[k];
      end
      carry_o[i+1] = acc | prod;
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GW = 8
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          c_i,
  output logic [GW-1:0] sum_o,
  output logic          c_o
);
  logic [GW-1:0] gen;
  logic [GW-1:0] prop;
  logic [GW:0]   carry;

  cla_pg_bits #(.N(GW)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen),
    .prop_o (prop)
  );

  cla_lookahead #(.N(GW)) u_la (
    .gen_i   (gen),
    .prop_i  (prop),
    .c_i     (c_i),
    .carry_o (carry)
  );

  assign sum_o = prop ^ carry[GW-1:0];
  assign c_o   = carry[GW];

  always_comb begin
    logic [GW:0] slice_ref;
    slice_ref = {1'b0, a_i} + {1'b0, b_i} + {{GW{1'b0}}, c_i};
    AST_GRP_COUT: assert (c_o == slice_ref[GW]); // R4
    AST_GRP_MAJ: assert (c_o == maj3(a_i[GW-1], b_i[GW-1], carry[GW-1])); // R5
  end
endmodule

// File: rtl/cla_grouped_adder.sv
module cla_grouped_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH   = CLA_DEF_WIDTH,
  parameter int unsigned GROUP_W = CLA_DEF_GROUP
) (
  input  logic [WIDTH-1:0] a_op,
  input  logic [WIDTH-1:0] b_op,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_out
);
  localparam int unsigned NGRP = WIDTH / GROUP_W;

  if ((WIDTH % GROUP_W) != 0 || GROUP_W == 0) begin : g_bad_cfg
    $error("slice width must divide operand width");
  end

  logic [NGRP:0] grp_c;
  assign grp_c[0] = c_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    cla_group #(.GW(GROUP_W)) u_grp (
      .a_i   (a_op[g*GROUP_W +: GROUP_W]),
      .b_i   (b_op[g*GROUP_W +: GROUP_W]),
      .c_i   (grp_c[g]),
      .sum_o (sum_o[g*GROUP_W +: GROUP_W]),
      .c_o   (grp_c[g+1])
    );
  end

  assign c_out = grp_c[NGRP];

  always_comb begin
    logic [WIDTH:0] total_ref;
    total_ref = {1'b0, a_op} + {1'b0, b_op} + {{WIDTH{1'b0}}, c_in};
    AST_SUM_TOTAL: assert ({c_out, sum_o} == total_ref); // R1
  end
endmodule

// File: tb/sim_cla_grouped_adder.sv
module ref_ripple_adder #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);
  logic [N:0] rc;
  assign rc[0] = ci;
  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s[i]    = x[i] ^ y[i] ^ rc[i];
    assign rc[i+1] = (x[i] & y[i]) | (x[i] & rc[i]) | (y[i] & rc[i]);
  end
  assign co = rc[N];
endmodule

module sim_cla_grouped_adder;
  localparam int unsigned W        = 32;
  localparam int unsigned GW       = 8;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WDOG_LIM = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [W-1:0] a, b, s, rs;
  logic         ci, co, rco;
  logic [3:0]   a4, b4, s4;
  logic         ci4, co4;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  cla_grouped_adder #(.WIDTH(W), .GROUP_W(GW)) u0 (
    .a_op(a), .b_op(b), .c_in(ci), .sum_o(s), .c_out(co)
  );
  ref_ripple_adder #(.N(W)) u_ref (.x(a), .y(b), .ci(ci), .s(rs), .co(rco));
  cla_grouped_adder #(.WIDTH(4), .GROUP_W(4)) u1 (
    .a_op(a4), .b_op(b4), .c_in(ci4), .sum_o(s4), .c_out(co4)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIM) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected<%0d", cyc, WDOG_LIM);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; ci = cv;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] av,
                     input logic [W-1:0] bv, input logic cv);
    logic [W:0] exp_v;
    apply(av, bv, cv);
    exp_v = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    n_chk++;
    if ({co, s} !== exp_v) begin
      n_bad++;
      $display("FAIL %s R1: a=%h b=%h ci=%b got=%h exp=%h", tag, av, bv, cv, {co, s}, exp_v);
    end
    n_chk++;
    if ({co, s} !== {rco, rs}) begin
      n_bad++;
      $display("FAIL %s R8: got=%h ripple=%h", tag, {co, s}, {rco, rs});
    end
  endtask

  task automatic t_idle;
    chk("idle R1", '0, '0, 1'b0);
  endtask

  task automatic t_extremes;
    chk("zeros+cin R3", '0, '0, 1'b1);
    chk("ones R1", '1, '1, 1'b0);
    chk("ones+cin R1", '1, '1, 1'b1);
    chk("alt R2", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    chk("alt+cin R6", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
  endtask

  task automatic t_boundaries;
    for (int k = 1; k <= int'(W / GW); k++) begin
      logic [W:0] mask;
      mask = ({{W{1'b0}}, 1'b1} << (k * GW)) - 1;
      chk("boundary R6", mask[W-1:0], '0, 1'b1);
      chk("boundary-gen R4", mask[W-1:0], 32'h1, 1'b0);
    end
    chk("full-chain R6", '1, '0, 1'b1);
    n_chk++;
    if (co !== 1'b1 || s !== '0) begin
      n_bad++;
      $display("FAIL R6: full chain got co=%b s=%h exp co=1 s=0", co, s);
    end
  endtask

  task automatic t_random(input logic cv);
    for (int i = 0; i < 300; i++) begin
      chk("random R5", W'($urandom), W'($urandom), cv);
    end
  endtask

  task automatic t_four_bit;
    for (int i = 0; i < 512; i++) begin
      logic [4:0] exp4;
      @(negedge clk);
      a4 = 4'(i); b4 = 4'(i >> 4); ci4 = i[8];
      @(posedge clk);
      #1;
      exp4 = {1'b0, a4} + {1'b0, b4} + {4'b0, ci4};
      n_chk++;
      if ({co4, s4} !== exp4) begin
        n_bad++;
        $display("FAIL R7: a=%h b=%h ci=%b got=%h exp=%h", a4, b4, ci4, {co4, s4}, exp4);
      end
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    a4 = '0; b4 = '0; ci4 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_extremes();
    t_boundaries();
    t_random(1'b0);
    t_random(1'b1);
    t_four_bit();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule